// File: doc/BRIEF.md
# Fixed-Feature Power Management Event Controller

This block holds the fixed-feature power management registers of a system controller and presents them on a single 16-bit register port. A free-running tick counter stands in for the power management timer. It advances once for each cycle in which a tick-enable input is high; in the target system that enable runs at 3.579545 MHz. The timer raises an overflow event each time its top bit toggles.

Event sources set bits in a write-one-to-clear status register. These sources are the timer overflow, a global-lock event, a real-time-clock alarm, the power button and resume. An enable register masks four of the status bits, and the masked bits are OR-ed into a level-sensitive SCI output.

A control register holds the SCI routing bit and a three-bit sleep type. When software writes the control register with the suspend-trigger bit set, the block acts on the sleep type. It emits a one-cycle pulse requesting soft power-off, a reset on resume, or entry to S3. A byte-wide APM command port switches SCI routing on or off with two fixed codes, and it raises an SMI pulse when SMI generation is allowed.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, every register reads 0 at offsets 0x0 (status), 0x2 (enable), 0x4 (control), 0x8 (timer low half), 0xA (timer high half) and 0xC (APM command), and `sci_o` is low.
- R2: The timer increments by one for each clock cycle with `tick_en` high and holds otherwise. Offset 0x8 returns timer bits 15:0. Offset 0xA returns bits 31:16, with every bit at or above `TMR_W` read as 0.
- R3: Status bit 0 (timer overflow) sets whenever an increment changes timer bit `TMR_W-1`, including the wrap to zero. After software clears it, the bit sets again at the next such toggle.
- R4: Writing offset 0x0 clears each status bit written as 1 and leaves bits written as 0 unchanged. Only bits 0, 5, 8, 10 and 15 exist; all other bits read 0.
- R5: `sci_o` is high exactly when status AND enable is non-zero in any of bits 0, 5, 8 or 10.
- R6: A `pwr_btn` pulse sets status bit 8 only while enable bit 8 is 1.
- R7: Control offset 0x4 stores all written bits except bit 13 (suspend trigger), which always reads 0. Bit 0 is SCI routing and bits 12:10 are the sleep type.
- R8: A control write with bit 13 set and sleep type 0 gives a one-cycle `soft_off_o` pulse in the cycle after the write.
- R9: A control write with bit 13 set and sleep type 1 sets status bits 15 and 8 and gives a one-cycle `reset_req_o` pulse in the cycle after the write.
- R10: A control write with bit 13 set and sleep type 5 gives a one-cycle `s3_o` pulse in the cycle after the write. The same sleep type written with bit 13 clear gives no pulse.
- R11: Writing 0xF1 to APM offset 0xC sets control bit 0, and writing 0xF0 clears it. Any other code leaves control unchanged. The last code written reads back from offset 0xC.
- R12: An APM write gives a one-cycle `smi_o` pulse in the next cycle only if `smi_en` is high.
- R13: `gbl_evt` sets status bit 5 and `rtc_evt` sets status bit 10, whatever the enable register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance enable, one count per high cycle |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| pwr_btn | input | 1 | Power button event |
| gbl_evt | input | 1 | Global-lock release event |
| rtc_evt | input | 1 | Real-time-clock alarm event |
| smi_en | input | 1 | Allows SMI pulses on APM writes |
| sci_o | output | 1 | Level-sensitive SCI |
| soft_off_o | output | 1 | Soft power-off request pulse |
| reset_req_o | output | 1 | Reset-on-resume request pulse |
| s3_o | output | 1 | S3 entry pulse |
| smi_o | output | 1 | SMI pulse |

## Verification
The assertions assume a register write lasts one cycle and targets a single offset, so two setters never overlap. They also assume the event inputs are plain levels that are sampled on each edge. The stimulus drives every write and event for exactly one clock and holds `tick_en` low during register accesses. It runs with a 12-bit timer so that both the mid-range toggle and the wrap of the top bit happen within a short run. Event-set versus software-clear collisions are never driven, so the w1c check conditions only on the absence of a setter in that cycle.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
   localparam int REG_W = 16;

   typedef enum logic [3:0] {
      OFS_STS    = 4'h0,
      OFS_EN     = 4'h2,
      OFS_CTL    = 4'h4,
      OFS_TMR_LO = 4'h8,
      OFS_TMR_HI = 4'hA,
      OFS_APM    = 4'hC
   } reg_ofs_e;

   localparam int B_TMROF  = 0;
   localparam int B_GBL    = 5;
   localparam int B_PWRBTN = 8;
   localparam int B_RTC    = 10;
   localparam int B_RSM    = 15;

   localparam int B_SCIEN   = 0;
   localparam int B_SUSTRIG = 13;
   localparam int SLP_LSB   = 10;
   localparam int SLP_W     = 3;

   localparam logic [REG_W-1:0] SCI_MASK = REG_W'((1 << B_TMROF) | (1 << B_GBL) |
                                                  (1 << B_PWRBTN) | (1 << B_RTC));
   localparam logic [REG_W-1:0] STS_IMPL = SCI_MASK | REG_W'(1 << B_RSM);

   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [TMR_W-1:0] cnt,
   output logic             ovf_evt
);
   localparam int TOP = TMR_W - 1;

   generate
      if (TMR_W < 8 || TMR_W > 32) begin : g_bad_width
         $error("pm_tick_timer: TMR_W must lie in 8..32");
      end
   endgenerate

   logic [TMR_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt + TMR_W'(1);
   assign ovf_evt = tick_en && (cnt_nxt[TOP] != cnt[TOP]);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (tick_en) cnt <= cnt_nxt;
   end

   p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> cnt == TMR_W'($past(cnt) + TMR_W'(1)));
   p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt));
endmodule

// File: rtl/pm_sts_en.sv
module pm_sts_en
   import pm_event_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sts,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             ovf_evt,
   input  logic             pwr_btn,
   input  logic             gbl_evt,
   input  logic             rtc_evt,
   input  logic             rsm_set,
   output logic [REG_W-1:0] sts,
   output logic [REG_W-1:0] en,
   output logic             sci
);
   logic [REG_W-1:0] set_vec, clr_vec, sts_nxt;

   always_comb begin
      set_vec           = '0;
      set_vec[B_TMROF]  = ovf_evt;
      set_vec[B_GBL]    = gbl_evt;
      set_vec[B_PWRBTN] = (pwr_btn && en[B_PWRBTN]) || rsm_set;
      set_vec[B_RTC]    = rtc_evt;
      set_vec[B_RSM]    = rsm_set;
   end

   assign clr_vec = wr_sts ? (wdata & STS_IMPL) : '0;

   generate
      if (SET_WINS) begin : g_set_wins
         assign sts_nxt = ((sts & ~clr_vec) | set_vec) & STS_IMPL;
      end else begin : g_clr_wins
         assign sts_nxt = ((sts | set_vec) & ~clr_vec) & STS_IMPL;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts <= '0;
         en  <= '0;
      end else begin
         sts <= sts_nxt;
         if (wr_en) en <= wdata;
      end
   end

   assign sci = |(sts & en & SCI_MASK);

   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wdata[B_TMROF] && !ovf_evt) |=> !sts[B_TMROF]);
   p_pwrbtn_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_btn && !en[B_PWRBTN] && !rsm_set && !sts[B_PWRBTN]) |=> !sts[B_PWRBTN]);
   p_sci_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((en & SCI_MASK) == '0) |-> !sci);
endmodule

// File: rtl/pm_ctl_apm.sv
module pm_ctl_apm
   import pm_event_pkg::*;
#(
   parameter int SLP_OFF    = 0,
   parameter int SLP_RESUME = 1,
   parameter int SLP_S3     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic             wr_apm,
   input  logic [REG_W-1:0] wdata,
   input  logic             smi_en,
   output logic [REG_W-1:0] ctl,
   output logic [7:0]       apm_cmd,
   output logic             rsm_set,
   output logic             soft_off,
   output logic             reset_req,
   output logic             s3,
   output logic             smi
);
   localparam int SLP_MAX = (1 << SLP_W) - 1;

   generate
      if (SLP_OFF > SLP_MAX || SLP_RESUME > SLP_MAX || SLP_S3 > SLP_MAX) begin : g_bad_slp
         $error("pm_ctl_apm: sleep type codes exceed the field width");
      end
      if (SLP_OFF == SLP_RESUME || SLP_OFF == SLP_S3 || SLP_RESUME == SLP_S3) begin : g_dup_slp
         $error("pm_ctl_apm: sleep type codes must differ");
      end
   endgenerate

   logic [SLP_W-1:0] slp;
   logic             trig;

   assign slp     = wdata[SLP_LSB +: SLP_W];
   assign trig    = wr_ctl && wdata[B_SUSTRIG];
   assign rsm_set = trig && (slp == SLP_W'(SLP_RESUME));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl       <= '0;
         apm_cmd   <= '0;
         soft_off  <= 1'b0;
         reset_req <= 1'b0;
         s3        <= 1'b0;
         smi       <= 1'b0;
      end else begin
         soft_off  <= trig && (slp == SLP_W'(SLP_OFF));
         reset_req <= rsm_set;
         s3        <= trig && (slp == SLP_W'(SLP_S3));
         smi       <= wr_apm && smi_en;
         if (wr_ctl) begin
            ctl <= wdata & ~(REG_W'(1) << B_SUSTRIG);
         end else if (wr_apm) begin
            if (wdata[7:0] == APM_SCI_ON)       ctl[B_SCIEN] <= 1'b1;
            else if (wdata[7:0] == APM_SCI_OFF) ctl[B_SCIEN] <= 1'b0;
         end
         if (wr_apm) apm_cmd <= wdata[7:0];
      end
   end

   p_pulse_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({soft_off, reset_req, s3}));
   p_soft_off_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_off && !wr_ctl) |=> !soft_off);
   p_smi_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_apm && !smi_en) |=> !smi);
   p_apm_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_apm && wdata[7:0] != APM_SCI_ON && wdata[7:0] != APM_SCI_OFF) |=> $stable(ctl));
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
   import pm_event_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int TMR_W      = 24,
   parameter bit SET_WINS   = 1'b1,
   parameter int SLP_OFF    = 0,
   parameter int SLP_RESUME = 1,
   parameter int SLP_S3     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              pwr_btn,
   input  logic              gbl_evt,
   input  logic              rtc_evt,
   input  logic              smi_en,
   output logic              sci_o,
   output logic              soft_off_o,
   output logic              reset_req_o,
   output logic              s3_o,
   output logic              smi_o
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pm_event_ctrl: ADDR_W must be at least 4");
      end
   endgenerate

   logic             hit_sts, hit_en, hit_ctl, hit_apm;
   logic [TMR_W-1:0] cnt;
   logic             ovf_evt, rsm_set;
   logic [REG_W-1:0] sts, en, ctl;
   logic [7:0]       apm_cmd;
   logic [31:0]      cnt32;

   assign hit_sts = reg_wr && (reg_addr == ADDR_W'(OFS_STS));
   assign hit_en  = reg_wr && (reg_addr == ADDR_W'(OFS_EN));
   assign hit_ctl = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
   assign hit_apm = reg_wr && (reg_addr == ADDR_W'(OFS_APM));

   pm_tick_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cnt     (cnt),
      .ovf_evt (ovf_evt)
   );

   pm_sts_en #(.SET_WINS(SET_WINS)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sts  (hit_sts),
      .wr_en   (hit_en),
      .wdata   (reg_wdata),
      .ovf_evt (ovf_evt),
      .pwr_btn (pwr_btn),
      .gbl_evt (gbl_evt),
      .rtc_evt (rtc_evt),
      .rsm_set (rsm_set),
      .sts     (sts),
      .en      (en),
      .sci     (sci_o)
   );

   pm_ctl_apm #(
      .SLP_OFF    (SLP_OFF),
      .SLP_RESUME (SLP_RESUME),
      .SLP_S3     (SLP_S3)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (hit_ctl),
      .wr_apm    (hit_apm),
      .wdata     (reg_wdata),
      .smi_en    (smi_en),
      .ctl       (ctl),
      .apm_cmd   (apm_cmd),
      .rsm_set   (rsm_set),
      .soft_off  (soft_off_o),
      .reset_req (reset_req_o),
      .s3        (s3_o),
      .smi       (smi_o)
   );

   assign cnt32 = 32'(cnt);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_STS))         reg_rdata = sts;
      else if (reg_addr == ADDR_W'(OFS_EN))     reg_rdata = en;
      else if (reg_addr == ADDR_W'(OFS_CTL))    reg_rdata = ctl;
      else if (reg_addr == ADDR_W'(OFS_TMR_LO)) reg_rdata = cnt32[15:0];
      else if (reg_addr == ADDR_W'(OFS_TMR_HI)) reg_rdata = cnt32[31:16];
      else if (reg_addr == ADDR_W'(OFS_APM))    reg_rdata = {8'h00, apm_cmd};
   end

   p_resume_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsm_set |=> (sts[B_RSM] && sts[B_PWRBTN] && reset_req_o));
   p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> sts[B_TMROF]);
   p_gbl_sets_r13: assert property (@(posedge clk) disable iff (!rst_n)
      gbl_evt |=> sts[B_GBL]);
endmodule

// File: tb/pm_event_ctrl_test.sv
module pm_event_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        pwr_btn = 1'b0, gbl_evt = 1'b0, rtc_evt = 1'b0, smi_en = 1'b0;
   logic        sci_o, soft_off_o, reset_req_o, s3_o, smi_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit mon_go = 1'b0;

   typedef struct {
      logic [15:0] val;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   pm_event_ctrl #(.ADDR_W(4), .TMR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwr_btn(pwr_btn), .gbl_evt(gbl_evt), .rtc_evt(rtc_evt), .smi_en(smi_en),
      .sci_o(sci_o), .soft_off_o(soft_off_o), .reset_req_o(reset_req_o),
      .s3_o(s3_o), .smi_o(smi_o)
   );

   // monitor: pops expected read data and compares at the falling edge
   always @(negedge clk) begin
      if (mon_go && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (reg_rdata !== e.val) begin
            errors++;
            $display("FAIL %s: read got %h expected %h", e.tag, reg_rdata, e.val);
         end
      end
   end

   task automatic expect_rd(input logic [3:0] a, input logic [15:0] v, input string tag);
      exp_t e;
      @(posedge clk); #1;
      reg_addr = a;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
      mon_go = 1'b1;
      @(negedge clk); #1;
      mon_go = 1'b0;
   endtask

   task automatic chk(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1;
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   task automatic pulse_evt(input int which);
      @(posedge clk); #1;
      if (which == 0) gbl_evt = 1'b1;
      else if (which == 1) rtc_evt = 1'b1;
      else pwr_btn = 1'b1;
      @(posedge clk); #1;
      gbl_evt = 1'b0; rtc_evt = 1'b0; pwr_btn = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      expect_rd(4'h0, 16'h0000, "R1 status");
      expect_rd(4'h2, 16'h0000, "R1 enable");
      expect_rd(4'h4, 16'h0000, "R1 control");
      expect_rd(4'h8, 16'h0000, "R1 timer lo");
      expect_rd(4'hC, 16'h0000, "R1 apm");
      @(negedge clk); chk(sci_o, 1'b0, "R1 sci");

      // R2 counting only on tick_en
      repeat (5) @(posedge clk);
      expect_rd(4'h8, 16'h0000, "R2 hold");
      ticks(10);
      expect_rd(4'h8, 16'd10, "R2 count");

      // R3 overflow on top-bit toggle (12-bit timer)
      ticks(2037);
      expect_rd(4'h8, 16'h07FF, "R3 before toggle");
      expect_rd(4'h0, 16'h0000, "R3 no ovf yet");
      ticks(1);
      expect_rd(4'h0, 16'h0001, "R3 ovf set");
      expect_rd(4'h8, 16'h0800, "R3 count at toggle");
      expect_rd(4'hA, 16'h0000, "R2 upper half zero");

      // R4 w1c
      wr(4'h0, 16'h0000);
      expect_rd(4'h0, 16'h0001, "R4 write zero keeps");
      wr(4'h0, 16'hFFFF);
      expect_rd(4'h0, 16'h0000, "R4 write one clears");

      // R3 rearm at wrap
      ticks(2047);
      expect_rd(4'h0, 16'h0000, "R3 no ovf before wrap");
      ticks(1);
      expect_rd(4'h0, 16'h0001, "R3 ovf at wrap");
      expect_rd(4'h8, 16'h0000, "R3 wrapped count");
      wr(4'h0, 16'h0001);

      // R5 / R13 masked SCI
      wr(4'h2, 16'h0020);
      pulse_evt(0);
      expect_rd(4'h0, 16'h0020, "R13 gbl sets");
      chk(sci_o, 1'b1, "R5 sci gbl enabled");
      wr(4'h2, 16'h0000);
      @(negedge clk); chk(sci_o, 1'b0, "R5 sci masked off");
      wr(4'h0, 16'h0020);
      pulse_evt(1);
      expect_rd(4'h0, 16'h0400, "R13 rtc sets without enable");
      chk(sci_o, 1'b0, "R5 sci rtc not enabled");
      wr(4'h2, 16'h0400);
      @(negedge clk); chk(sci_o, 1'b1, "R5 sci rtc enabled");
      wr(4'h0, 16'h0400);
      @(negedge clk); chk(sci_o, 1'b0, "R5 sci after clear");
      wr(4'h2, 16'h0000);

      // R6 power button gating
      pulse_evt(2);
      expect_rd(4'h0, 16'h0000, "R6 button ignored");
      wr(4'h2, 16'h0100);
      pulse_evt(2);
      expect_rd(4'h0, 16'h0100, "R6 button sets");
      chk(sci_o, 1'b1, "R5 sci button");
      wr(4'h0, 16'h0100);
      wr(4'h2, 16'h0000);

      // R7 control storage, trigger bit reads zero
      wr(4'h4, 16'hFFFF);
      @(negedge clk);
      chk(soft_off_o | reset_req_o | s3_o, 1'b0, "R7 type 7 no pulse");
      expect_rd(4'h4, 16'hDFFF, "R7 trigger bit reads zero");
      wr(4'h4, 16'h0000);

      // R8 soft off
      wr(4'h4, 16'h2000);
      @(negedge clk); chk(soft_off_o, 1'b1, "R8 soft off pulse");
      @(negedge clk); chk(soft_off_o, 1'b0, "R8 soft off one cycle");
      expect_rd(4'h4, 16'h0000, "R8 control after");

      // R9 resume
      wr(4'h4, 16'h2400);
      @(negedge clk); chk(reset_req_o, 1'b1, "R9 reset pulse");
      @(negedge clk); chk(reset_req_o, 1'b0, "R9 reset one cycle");
      expect_rd(4'h0, 16'h8100, "R9 status set");
      expect_rd(4'h4, 16'h0400, "R9 control after");
      wr(4'h0, 16'h8100);

      // R10 S3
      wr(4'h4, 16'h3400);
      @(negedge clk); chk(s3_o, 1'b1, "R10 s3 pulse");
      @(negedge clk); chk(s3_o, 1'b0, "R10 s3 one cycle");
      wr(4'h4, 16'h1400);
      @(negedge clk); chk(s3_o, 1'b0, "R10 no trigger no pulse");
      expect_rd(4'h4, 16'h1400, "R10 control stored");
      wr(4'h4, 16'h0000);

      // R11 APM codes
      wr(4'hC, 16'h00F1);
      expect_rd(4'h4, 16'h0001, "R11 F1 sets sci route");
      expect_rd(4'hC, 16'h00F1, "R11 readback");
      wr(4'hC, 16'h0055);
      expect_rd(4'h4, 16'h0001, "R11 other code ignored");
      wr(4'hC, 16'h00F0);
      expect_rd(4'h4, 16'h0000, "R11 F0 clears sci route");

      // R12 SMI gating
      smi_en = 1'b0;
      wr(4'hC, 16'h0012);
      @(negedge clk); chk(smi_o, 1'b0, "R12 smi blocked");
      smi_en = 1'b1;
      wr(4'hC, 16'h0012);
      @(negedge clk); chk(smi_o, 1'b1, "R12 smi pulse");
      @(negedge clk); chk(smi_o, 1'b0, "R12 smi one cycle");

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule